// File: doc/BRIEF.md
# E1 Time-Slot-0 Spare and International Bit Access

This block gives a host direct access to the spare (Sa4 to Sa8) and international (Si) bit positions carried in time slot 0 of E1 frames. On the receive side, a framer presents each time-slot-0 byte together with a flag that says whether it came from an alignment frame or a non-alignment frame. The block keeps an alignment byte pending until the matching non-alignment byte arrives. It then moves both bytes into two host-visible registers and raises a sticky receive flag. The host has one double-frame period to read them before the next pair overwrites them.

On the transmit side, the framer requests a time-slot-0 byte once per frame. On each alignment-frame request the block samples the host's transmit values into shadow storage and raises a sticky transmit flag. If the host does not refresh its values before the next alignment frame, the same values are sent again. The alignment byte is built from the Si bit and the fixed alignment pattern. The non-alignment byte is built from Si, a forced 1, the remote-alarm bit and the five spare bits. Spare bits can be replaced one at a time by other sources. Si can be replaced by a serial-input source, by an automatic E-bit, or by the CRC4 multiframe bit. The CRC4 logic, E-bit logic and frame alignment detection sit outside this block and supply their results as inputs.

Top module: `e1_sasi_access`

## Requirements
- R1: After reset, both receive registers read 0, both flags are low and `tx_ts0_valid` is low.
- R2: When a non-alignment byte (`rx_ts0_is_align`=0) arrives after a pending alignment byte (`rx_ts0_is_align`=1), both receive registers and `rx_flag` update on the next cycle. If more than one alignment byte arrives first, the most recent one is used.
- R3: A non-alignment byte that arrives with no pending alignment byte leaves both receive registers and `rx_flag` unchanged.
- R4: `rx_flag` stays high until `rx_flag_clr` is pulsed. When a new pair completes in the same cycle as a clear, the flag stays set.
- R5: On an alignment request, the output byte is {Si, 7'b0011011}. The host byte is sampled at that same edge.
- R6: On a non-alignment request, the output byte is {Si, 1, A, Sa4..Sa8}. `host_tx_nalign` is 7 bits, arranged {Si, A, Sa4..Sa8}. The values used are the ones sampled at the last alignment request, so later host changes are not sent.
- R7: Each bit of `sa_src_en` (bit 4 = Sa4 … bit 0 = Sa8, matching output bits 4:0) replaces that Sa bit with the same bit of `sa_src_bits`.
- R8: Si is chosen in this priority order. First, `si_ser_en` selects `si_ser_bit`. Next, in non-alignment frames, `ebit_auto_en` selects `ebit_bit`. Next, `crc4_en` selects `crc_si_bit`. Otherwise, the host Si is used.
- R9: `tx_flag` sets on each alignment request and stays high until `tx_flag_clr` is pulsed. A request in the same cycle as a clear wins.
- R10: `tx_ts0_valid` is high exactly in the cycle after each request and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_ts0_valid | input | 1 | Received time-slot-0 byte strobe |
| rx_ts0_is_align | input | 1 | 1 = byte is from an alignment frame |
| rx_ts0_byte | input | 8 | Received time-slot-0 byte, MSB first on line |
| rx_align_byte | output | 8 | Captured alignment-frame byte |
| rx_nalign_byte | output | 8 | Captured non-alignment-frame byte |
| rx_flag | output | 1 | Sticky receive-update flag |
| rx_flag_clr | input | 1 | Write-one clear for rx_flag |
| tx_ts0_req | input | 1 | Request for a transmit time-slot-0 byte |
| tx_ts0_is_align | input | 1 | 1 = request is for an alignment frame |
| host_tx_align_si | input | 1 | Host Si for alignment frames |
| host_tx_nalign | input | 7 | Host {Si, A, Sa4..Sa8} for non-alignment frames |
| tx_flag | output | 1 | Sticky transmit-sample flag |
| tx_flag_clr | input | 1 | Write-one clear for tx_flag |
| si_ser_en | input | 1 | Si is taken from the serial input |
| si_ser_bit | input | 1 | Serial-input Si value |
| crc4_en | input | 1 | CRC4 multiframe mode enabled |
| crc_si_bit | input | 1 | Si value from the CRC4 logic |
| ebit_auto_en | input | 1 | Automatic E-bit insertion enabled |
| ebit_bit | input | 1 | E-bit value |
| sa_src_en | input | 5 | Per-Sa override enables |
| sa_src_bits | input | 5 | Per-Sa override values |
| tx_ts0_valid | output | 1 | Transmit byte valid |
| tx_ts0_byte | output | 8 | Transmit time-slot-0 byte |

## Verification
If the pending alignment byte is held in the wrong state, the receive registers show a stale or mismatched pair one cycle after the completing non-alignment byte. If the transmit shadow is corrupted, the fault shows up on the very next non-alignment request as a wrong A or Sa field, and it persists until the next alignment sample. A fault in the override selection is visible in bit 7 or bits 4:0 one cycle after the request that uses it. The bench walks override combinations across both frame types to separate each source.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;
   localparam int TS0_W   = 8;
   localparam int SA_CNT  = 5;
   localparam logic [6:0] ALIGN_WORD = 7'b0011011;

   typedef struct packed {
      logic ser_en;
      logic ser_bit;
      logic crc_en;
      logic crc_bit;
      logic eb_en;
      logic eb_bit;
   } si_ctl_t;
endpackage

// File: rtl/e1sa_rx_capture.sv
module e1sa_rx_capture #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic              in_align,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              flag_clr,
   output logic [BYTE_W-1:0] align_q,
   output logic [BYTE_W-1:0] nalign_q,
   output logic              flag
);
   logic [BYTE_W-1:0] pend_q;
   logic              pend_vld;
   logic              pair_done;

   assign pair_done = in_vld && !in_align && pend_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q   <= '0;
         pend_vld <= 1'b0;
         align_q  <= '0;
         nalign_q <= '0;
         flag     <= 1'b0;
      end else begin
         if (in_vld && in_align) begin
            pend_q   <= in_byte;
            pend_vld <= 1'b1;
         end
         if (pair_done) begin
            align_q  <= pend_q;
            nalign_q <= in_byte;
            pend_vld <= 1'b0;
         end
         if (pair_done)     flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
      end
   end

   p_pair_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pair_done |=> flag);
   p_orphan_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !in_align && !pend_vld) |=> ($stable(align_q) && $stable(nalign_q)));
   p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);
endmodule

// File: rtl/e1sa_si_select.sv
module e1sa_si_select
   import e1sa_pkg::*;
(
   input  si_ctl_t ctl,
   input  logic    is_align,
   input  logic    host_si,
   output logic    si_out
);
   always_comb begin
      if (ctl.ser_en)                    si_out = ctl.ser_bit;
      else if (ctl.eb_en && !is_align)   si_out = ctl.eb_bit;
      else if (ctl.crc_en)               si_out = ctl.crc_bit;
      else                               si_out = host_si;
   end
endmodule

// File: rtl/e1sa_tx_insert.sv
module e1sa_tx_insert #(
   parameter int         BYTE_W    = 8,
   parameter int         NUM_SA    = 5,
   parameter logic [6:0] ALIGN_PAT = 7'b0011011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              is_align,
   input  logic              host_align_si,
   input  logic [NUM_SA+1:0] host_nalign,
   input  logic              si_val,
   input  logic [NUM_SA-1:0] sa_en,
   input  logic [NUM_SA-1:0] sa_bits,
   input  logic              flag_clr,
   output logic              host_si,
   output logic              flag,
   output logic              out_vld,
   output logic [BYTE_W-1:0] out_byte
);
   localparam int SH_W = NUM_SA + 2;

   if (BYTE_W != NUM_SA + 3) begin : g_bad_width
      $error("e1sa_tx_insert: BYTE_W must equal NUM_SA+3");
   end

   logic [SH_W-1:0]   shadow_q;
   logic [NUM_SA-1:0] sa_mix;
   logic [BYTE_W-1:0] al_byte;
   logic [BYTE_W-1:0] nal_byte;

   for (genvar i = 0; i < NUM_SA; i++) begin : g_sa
      assign sa_mix[i] = sa_en[i] ? sa_bits[i] : shadow_q[i];
   end

   assign host_si  = is_align ? host_align_si : shadow_q[SH_W-1];
   assign al_byte  = {si_val, ALIGN_PAT};
   assign nal_byte = {si_val, 1'b1, shadow_q[NUM_SA], sa_mix};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         flag     <= 1'b0;
         out_vld  <= 1'b0;
         out_byte <= '0;
      end else begin
         out_vld <= req;
         if (req) out_byte <= is_align ? al_byte : nal_byte;
         if (req && is_align) shadow_q <= host_nalign;
         if (req && is_align) flag <= 1'b1;
         else if (flag_clr)   flag <= 1'b0;
      end
   end

   p_align_pattern_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && is_align) |=> (out_byte[BYTE_W-2:0] == ALIGN_PAT));
   p_nalign_bit6_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !is_align) |=> out_byte[BYTE_W-2]);
   p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req && is_align) |=> flag);
   p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> out_vld);
   p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !out_vld);
endmodule

// File: rtl/e1_sasi_access.sv
module e1_sasi_access
   import e1sa_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_ts0_valid,
   input  logic        rx_ts0_is_align,
   input  logic [7:0]  rx_ts0_byte,
   output logic [7:0]  rx_align_byte,
   output logic [7:0]  rx_nalign_byte,
   output logic        rx_flag,
   input  logic        rx_flag_clr,
   input  logic        tx_ts0_req,
   input  logic        tx_ts0_is_align,
   input  logic        host_tx_align_si,
   input  logic [6:0]  host_tx_nalign,
   output logic        tx_flag,
   input  logic        tx_flag_clr,
   input  logic        si_ser_en,
   input  logic        si_ser_bit,
   input  logic        crc4_en,
   input  logic        crc_si_bit,
   input  logic        ebit_auto_en,
   input  logic        ebit_bit,
   input  logic [4:0]  sa_src_en,
   input  logic [4:0]  sa_src_bits,
   output logic        tx_ts0_valid,
   output logic [7:0]  tx_ts0_byte
);
   si_ctl_t si_ctl;
   logic    host_si;
   logic    si_sel;

   assign si_ctl = '{ser_en: si_ser_en, ser_bit: si_ser_bit, crc_en: crc4_en,
                     crc_bit: crc_si_bit, eb_en: ebit_auto_en, eb_bit: ebit_bit};

   e1sa_rx_capture #(.BYTE_W(TS0_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .in_vld(rx_ts0_valid), .in_align(rx_ts0_is_align),
      .in_byte(rx_ts0_byte), .flag_clr(rx_flag_clr), .align_q(rx_align_byte),
      .nalign_q(rx_nalign_byte), .flag(rx_flag));

   e1sa_si_select u_si (
      .ctl(si_ctl), .is_align(tx_ts0_is_align), .host_si(host_si), .si_out(si_sel));

   e1sa_tx_insert #(.BYTE_W(TS0_W), .NUM_SA(SA_CNT), .ALIGN_PAT(ALIGN_WORD)) u_tx (
      .clk(clk), .rst_n(rst_n), .req(tx_ts0_req), .is_align(tx_ts0_is_align),
      .host_align_si(host_tx_align_si), .host_nalign(host_tx_nalign), .si_val(si_sel),
      .sa_en(sa_src_en), .sa_bits(sa_src_bits), .flag_clr(tx_flag_clr),
      .host_si(host_si), .flag(tx_flag), .out_vld(tx_ts0_valid), .out_byte(tx_ts0_byte));
endmodule

// File: tb/tb_e1_sasi_access.sv
module tb_e1_sasi_access;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_ts0_valid = 0, rx_ts0_is_align = 0, rx_flag_clr = 0;
   logic [7:0] rx_ts0_byte = '0;
   logic [7:0] rx_align_byte, rx_nalign_byte;
   logic rx_flag, tx_flag, tx_ts0_valid;
   logic tx_ts0_req = 0, tx_ts0_is_align = 0, host_tx_align_si = 0, tx_flag_clr = 0;
   logic [6:0] host_tx_nalign = '0;
   logic si_ser_en = 0, si_ser_bit = 0, crc4_en = 0, crc_si_bit = 0, ebit_auto_en = 0, ebit_bit = 0;
   logic [4:0] sa_src_en = '0, sa_src_bits = '0;
   logic [7:0] tx_ts0_byte;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   e1_sasi_access dut (.*);

   typedef struct packed {
      logic       al;
      logic       hsi;
      logic [6:0] hn;
      logic [5:0] ctl;
      logic [4:0] sen;
      logic [4:0] sb;
      logic [7:0] exp;
   } vec_t;

   // ctl = {ser_en, ser_bit, crc_en, crc_bit, ebit_en, ebit_bit}
   localparam logic [40:0] VEC [9] = '{
      {1'b1, 1'b1, 7'b1100101, 6'b000000, 5'b00000, 5'b00000, 8'h9B}, // R5 host Si
      {1'b0, 1'b0, 7'b0000000, 6'b000000, 5'b00000, 5'b00000, 8'hE5}, // R6 shadow used
      {1'b1, 1'b0, 7'b0011111, 6'b000000, 5'b00000, 5'b00000, 8'h1B}, // R5
      {1'b0, 1'b1, 7'b1111111, 6'b000000, 5'b10100, 5'b00000, 8'h4B}, // R7 Sa4,Sa6 forced
      {1'b0, 1'b0, 7'b0000000, 6'b001110, 5'b00000, 5'b00000, 8'h5F}, // R8 E-bit over CRC
      {1'b1, 1'b0, 7'b0000000, 6'b001110, 5'b00000, 5'b00000, 8'h9B}, // R8 CRC in align
      {1'b1, 1'b1, 7'b0000000, 6'b101100, 5'b00000, 5'b00000, 8'h1B}, // R8 serial wins
      {1'b0, 1'b0, 7'b0000000, 6'b110010, 5'b11111, 5'b10110, 8'hD6}, // R7 R8
      {1'b0, 1'b0, 7'b0000000, 6'b000000, 5'b00000, 5'b00000, 8'h40}  // R6
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rx_send(input logic al, input logic [7:0] b);
      @(negedge clk);
      rx_ts0_valid = 1; rx_ts0_is_align = al; rx_ts0_byte = b;
      @(negedge clk);
      rx_ts0_valid = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 rx_align", rx_align_byte, 0);
      check("R1 rx_nalign", rx_nalign_byte, 0);
      check("R1 flags", {rx_flag, tx_flag, tx_ts0_valid}, 0);

      // Receive path
      rx_send(0, 8'h77);
      check("R3 orphan regs", {rx_align_byte, rx_nalign_byte}, 0);
      check("R3 orphan flag", rx_flag, 0);
      rx_send(1, 8'h9B);
      rx_send(0, 8'h5A);
      check("R2 pair", {rx_align_byte, rx_nalign_byte}, 16'h9B5A);
      check("R2 flag", rx_flag, 1);
      @(negedge clk);
      check("R4 sticky", rx_flag, 1);
      rx_flag_clr = 1; @(negedge clk); rx_flag_clr = 0;
      check("R4 clear", rx_flag, 0);
      rx_send(1, 8'h1B);
      rx_send(1, 8'h9A);
      @(negedge clk);
      rx_ts0_valid = 1; rx_ts0_is_align = 0; rx_ts0_byte = 8'h3C; rx_flag_clr = 1;
      @(negedge clk);
      rx_ts0_valid = 0; rx_flag_clr = 0;
      check("R2 latest align", {rx_align_byte, rx_nalign_byte}, 16'h9A3C);
      check("R4 set beats clear", rx_flag, 1);
      rx_send(0, 8'h11);
      check("R3 after pair", {rx_align_byte, rx_nalign_byte}, 16'h9A3C);

      // Transmit vector table
      for (int i = 0; i < 9; i++) begin
         vec_t v;
         v = vec_t'(VEC[i]);
         @(negedge clk);
         tx_ts0_req = 1; tx_ts0_is_align = v.al; host_tx_align_si = v.hsi;
         host_tx_nalign = v.hn;
         {si_ser_en, si_ser_bit, crc4_en, crc_si_bit, ebit_auto_en, ebit_bit} = v.ctl;
         sa_src_en = v.sen; sa_src_bits = v.sb;
         @(negedge clk);
         tx_ts0_req = 0;
         check($sformatf("R5/R6/R7/R8 vec%0d byte", i), tx_ts0_byte, v.exp);
         check($sformatf("R10 vec%0d valid", i), tx_ts0_valid, 1);
      end
      @(negedge clk);
      check("R10 idle", tx_ts0_valid, 0);
      check("R9 sticky", tx_flag, 1);
      tx_flag_clr = 1; @(negedge clk); tx_flag_clr = 0;
      check("R9 clear", tx_flag, 0);
      {si_ser_en, crc4_en, ebit_auto_en} = 3'b000; sa_src_en = '0;
      tx_ts0_req = 1; tx_ts0_is_align = 1; host_tx_align_si = 0; tx_flag_clr = 1;
      @(negedge clk);
      tx_ts0_req = 0; tx_flag_clr = 0;
      check("R9 set beats clear", tx_flag, 1);
      check("R5 align byte", tx_ts0_byte, 8'h1B);

      rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
      check("R1 after reset", {rx_flag, tx_flag, tx_ts0_valid, rx_align_byte}, 0);
      finish_run();
   end
endmodule